// File: doc/BRIEF.md
# Radix page table walker

This block turns a virtual page number into a physical page number. It does so by reading a radix-tree page table out of physical memory, one level at a time. A TLB controller hands it one walk request, together with the root table pointer from a control register and a mode bit that picks a 4-level or a 3-level walk.

The walker then issues a chain of dependent reads on a memory request/response port, which a data cache may serve with any latency. Each read address is built from the frame held in the previous entry and the nine virtual page number bits that index the current level. Every read address is physical, so a walk never needs a translation of its own.

The walk ends in one of three ways. It can return a 4 KiB translation, a 2 MiB or 1 GiB large-page translation, or a fault. The result appears as a one-cycle pulse. Only one walk is active at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid` and `done_valid` are 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays 0 from the cycle after acceptance until the cycle in which `done_valid` is high. Requests presented while busy, and changes to `req_vpn`, `req_short` or `root_ppn` while busy, have no effect on the walk in progress.
- R3: The first read of a walk goes to address {root_ppn, index, 3'b000}. In 4-level mode (`req_short`=0) the index is vpn[35:27], the level-4 index. In 3-level mode (`req_short`=1) the walk starts at level 3 and the index is vpn[26:18].
- R4: Each later read goes to address {entry[39:12] of the previous entry, index of the next lower level, 3'b000}. The level-n index is vpn[9n-1:9n-9]. No read is issued until the response to the previous read has arrived.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and the address does not change.
- R6: An entry whose bit 0 (valid) is 0 ends the walk with `done_fault`=1, at any level.
- R7: An entry that is valid and has bit 1 (leaf) set at level 4 ends the walk with `done_fault`=1.
- R8: Any valid entry at level 1 ends the walk with `done_fault`=0, `done_size`=0 and `done_ppn`=entry[39:12], whatever the leaf bit is.
- R9: A valid entry with the leaf bit set at level 2 gives `done_size`=1. At level 3 it gives `done_size`=2. In both cases `done_ppn` takes its low 9 (level 2) or 18 (level 3) bits from the virtual page number and the rest from entry[39:12].
- R10: `done_valid` is high for exactly one cycle, the cycle after the final response is taken. On a fault, `done_ppn` and `done_size` are 0.
- R11: In 3-level mode, vpn[35:27] has no effect on the read addresses or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpn | input | 36 | Virtual page number to translate |
| req_short | input | 1 | 1 selects a 3-level walk, 0 a 4-level walk |
| root_ppn | input | 28 | Physical page number of the root table |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 40 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry read |
| done_valid | output | 1 | One-cycle result pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_ppn | output | 28 | Translated physical page number (4 KiB granule) |
| done_size | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |

## Verification
A wrong current level or a wrong table pointer shows up at the next read address. That address is on the port one cycle after the response that produced it, so the bench compares every read address against a walk computed from its own copy of memory. A wrong decision on an entry shows in two ways: a read appears where a result pulse was due, or the pulse comes one cycle after the response with the wrong fault, size or page. A state machine that stalls or leaves its idle state early shows within one cycle on `req_ready` or `mem_req_valid`, and both are compared on every clock.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ISSUE = 2'd1,
        WS_WAIT  = 2'd2
    } walk_state_e;

    typedef enum logic [1:0] {
        EK_FAULT = 2'd0,
        EK_LEAF  = 2'd1,
        EK_NEXT  = 2'd2
    } entry_kind_e;

    localparam int ENTRY_VALID_BIT = 0;
    localparam int ENTRY_LEAF_BIT  = 1;

    // level at which a walk begins for the selected mode
    function automatic int unsigned first_level(input logic shrt, input int unsigned levels);
        return shrt ? levels - 1 : levels;
    endfunction

endpackage

// File: rtl/pt_walker_idx_sel.sv
module pt_walker_idx_sel #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int LVL_W  = 3
) (
    input  logic [LEVELS*IDX_W-1:0] vpn,
    input  logic [LVL_W-1:0]        level,
    output logic [IDX_W-1:0]        idx
);
    logic [IDX_W-1:0] slice [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vpn[g*IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int l = 1; l <= LEVELS; l++) begin
            if (level == LVL_W'(l)) idx = slice[l-1];
        end
    end
endmodule

// File: rtl/pt_walker_entry_dec.sv
module pt_walker_entry_dec
    import pt_walker_pkg::*;
#(
    parameter int ENTRY_W      = 64,
    parameter int PPN_W        = 28,
    parameter int OFF_W        = 12,
    parameter int LVL_W        = 3,
    parameter int MAX_LEAF_LVL = 3
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [LVL_W-1:0]   level,
    output entry_kind_e        kind,
    output logic [PPN_W-1:0]   ppn
);
    logic ent_valid;
    logic ent_leaf;
    logic unused_bits;

    assign ent_valid   = entry[ENTRY_VALID_BIT];
    assign ent_leaf    = entry[ENTRY_LEAF_BIT];
    assign ppn         = entry[OFF_W +: PPN_W];
    assign unused_bits = ^{entry[ENTRY_W-1:OFF_W+PPN_W], entry[OFF_W-1:ENTRY_LEAF_BIT+1]};

    always_comb begin
        if (!ent_valid)
            kind = EK_FAULT;
        else if (level == LVL_W'(1))
            kind = EK_LEAF;
        else if (ent_leaf)
            kind = (level <= LVL_W'(MAX_LEAF_LVL)) ? EK_LEAF : EK_FAULT;
        else
            kind = EK_NEXT;
    end
endmodule

// File: rtl/pt_walker_leaf_fmt.sv
module pt_walker_leaf_fmt #(
    parameter int PPN_W        = 28,
    parameter int IDX_W        = 9,
    parameter int LVL_W        = 3,
    parameter int MAX_LEAF_LVL = 3,
    localparam int MERGE_W     = IDX_W * (MAX_LEAF_LVL - 1)
) (
    input  logic [PPN_W-1:0]   base_ppn,
    input  logic [MERGE_W-1:0] vpn_lo,
    input  logic [LVL_W-1:0]   level,
    output logic [PPN_W-1:0]   leaf_ppn
);
    logic [PPN_W-1:0] merged [MAX_LEAF_LVL];

    for (genvar g = 0; g < MAX_LEAF_LVL; g++) begin : g_merge
        if (g == 0) begin : g_base
            assign merged[g] = base_ppn;
        end else begin : g_large
            assign merged[g] = {base_ppn[PPN_W-1:g*IDX_W], vpn_lo[g*IDX_W-1:0]};
        end
    end

    always_comb begin
        leaf_ppn = base_ppn;
        for (int l = 1; l <= MAX_LEAF_LVL; l++) begin
            if (level == LVL_W'(l)) leaf_ppn = merged[l-1];
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int LEVELS        = 4,
    parameter int IDX_W         = 9,
    parameter int PA_W          = 40,
    parameter int ENTRY_W       = 64,
    parameter int MAX_LEAF_LVL  = 3,
    localparam int ENT_OFF_W    = $clog2(ENTRY_W / 8),
    localparam int OFF_W        = IDX_W + ENT_OFF_W,
    localparam int PPN_W        = PA_W - OFF_W,
    localparam int VPN_W        = LEVELS * IDX_W,
    localparam int SZ_W         = $clog2(MAX_LEAF_LVL)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic               req_short,
    input  logic [PPN_W-1:0]   root_ppn,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               done_valid,
    output logic               done_fault,
    output logic [PPN_W-1:0]   done_ppn,
    output logic [SZ_W-1:0]    done_size
);
    localparam int LVL_W   = $clog2(LEVELS + 1);
    localparam int MERGE_W = IDX_W * (MAX_LEAF_LVL - 1);

    typedef struct packed {
        logic             fault;
        logic [PPN_W-1:0] ppn;
        logic [SZ_W-1:0]  size;
    } walk_result_t;

    walk_state_e      st_q;
    logic [LVL_W-1:0] lvl_q;
    logic [PPN_W-1:0] tbl_q;
    logic [VPN_W-1:0] vpn_q;
    walk_result_t     res_q;
    logic             done_q;

    logic [IDX_W-1:0] cur_idx;
    entry_kind_e      ent_kind;
    logic [PPN_W-1:0] ent_ppn;
    logic [PPN_W-1:0] leaf_ppn;

    pt_walker_idx_sel #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .LVL_W(LVL_W)
    ) u_idx (
        .vpn(vpn_q), .level(lvl_q), .idx(cur_idx)
    );

    pt_walker_entry_dec #(
        .ENTRY_W(ENTRY_W), .PPN_W(PPN_W), .OFF_W(OFF_W),
        .LVL_W(LVL_W), .MAX_LEAF_LVL(MAX_LEAF_LVL)
    ) u_dec (
        .entry(mem_rsp_data), .level(lvl_q), .kind(ent_kind), .ppn(ent_ppn)
    );

    pt_walker_leaf_fmt #(
        .PPN_W(PPN_W), .IDX_W(IDX_W), .LVL_W(LVL_W), .MAX_LEAF_LVL(MAX_LEAF_LVL)
    ) u_leaf (
        .base_ppn(ent_ppn), .vpn_lo(vpn_q[MERGE_W-1:0]), .level(lvl_q), .leaf_ppn(leaf_ppn)
    );

    assign req_ready     = (st_q == WS_IDLE);
    assign mem_req_valid = (st_q == WS_ISSUE);
    assign mem_req_addr  = {tbl_q, cur_idx, {ENT_OFF_W{1'b0}}};

    assign done_valid = done_q;
    assign done_fault = res_q.fault;
    assign done_ppn   = res_q.ppn;
    assign done_size  = res_q.size;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WS_IDLE;
            lvl_q  <= '0;
            tbl_q  <= '0;
            vpn_q  <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        vpn_q <= req_vpn;
                        tbl_q <= root_ppn;
                        lvl_q <= LVL_W'(first_level(req_short, LEVELS));
                        st_q  <= WS_ISSUE;
                    end
                end
                WS_ISSUE: begin
                    if (mem_req_ready) st_q <= WS_WAIT;
                end
                WS_WAIT: begin
                    if (mem_rsp_valid) begin
                        case (ent_kind)
                            EK_NEXT: begin
                                tbl_q <= ent_ppn;
                                lvl_q <= lvl_q - LVL_W'(1);
                                st_q  <= WS_ISSUE;
                            end
                            EK_LEAF: begin
                                res_q.fault <= 1'b0;
                                res_q.ppn   <= leaf_ppn;
                                res_q.size  <= SZ_W'(lvl_q - LVL_W'(1));
                                done_q      <= 1'b1;
                                st_q        <= WS_IDLE;
                            end
                            default: begin
                                res_q.fault <= 1'b1;
                                res_q.ppn   <= '0;
                                res_q.size  <= '0;
                                done_q      <= 1'b1;
                                st_q        <= WS_IDLE;
                            end
                        endcase
                    end
                end
                default: st_q <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int PA_W      = 40,
    parameter int PPN_W     = 28,
    parameter int SZ_W      = 2,
    parameter int ENT_OFF_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             done_valid,
    input logic             done_fault,
    input logic [PPN_W-1:0] done_ppn,
    input logic [SZ_W-1:0]  done_size
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst)
            outstanding <= 1'b0;
        else if (mem_req_valid && mem_req_ready)
            outstanding <= 1'b1;
        else if (mem_rsp_valid)
            outstanding <= 1'b0;
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    // R4
    serial_read_chk: assert property (@(posedge clk) disable iff (rst)
        outstanding |-> !mem_req_valid);

    // R4
    entry_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_addr[ENT_OFF_W-1:0] == '0);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    // R10
    done_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_valid) |-> $past(mem_rsp_valid));

    // R10
    fault_clean_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault |-> done_ppn == '0 && done_size == '0);
endmodule

bind pt_walker pt_walker_chk #(
    .PA_W(PA_W), .PPN_W(PPN_W), .SZ_W(SZ_W), .ENT_OFF_W(ENT_OFF_W)
) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .done_valid(done_valid), .done_fault(done_fault),
    .done_ppn(done_ppn), .done_size(done_size)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
    localparam int NW = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [35:0] req_vpn;
    logic        req_short;
    logic [27:0] root_ppn;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [39:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        done_valid;
    logic        done_fault;
    logic [27:0] done_ppn;
    logic [1:0]  done_size;

    always #2 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_short(req_short), .root_ppn(root_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done_valid(done_valid),
        .done_fault(done_fault), .done_ppn(done_ppn), .done_size(done_size)
    );

    int checks = 0;
    int errors = 0;

    logic [63:0] pmem [logic [39:0]];
    logic [39:0] exp_q [$];
    bit          exp_fault;
    logic [27:0] exp_ppn;
    logic [1:0]  exp_size;

    logic [35:0] w_vpn   [NW];
    bit          w_short [NW];
    logic [27:0] w_root  [NW];
    string       w_tag   [NW];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [39:0] a);
        return pmem.exists(a) ? pmem[a] : 64'h0;
    endfunction

    function automatic logic [35:0] mk_vpn(input int a, input int b, input int c, input int d);
        return {9'(a), 9'(b), 9'(c), 9'(d)};
    endfunction

    function automatic logic [39:0] ea(input logic [27:0] tbl, input int idx);
        return {tbl, 9'(idx), 3'b000};
    endfunction

    function automatic logic [63:0] ptr_e(input logic [27:0] p);
        return {24'h0, p, 10'h0, 2'b01};
    endfunction

    function automatic logic [63:0] leaf_e(input logic [27:0] p, input logic [23:0] hi);
        return {hi, p, 10'h0, 2'b11};
    endfunction

    // expected walk from the requirements, run over the bench's memory image
    task automatic ref_walk(input logic [35:0] vpn, input bit shrt, input logic [27:0] root);
        int          lvl;
        logic [27:0] tbl;
        logic [63:0] e;
        logic [39:0] a;
        logic [35:0] m;
        exp_q.delete();
        lvl = shrt ? 3 : 4;
        tbl = root;
        exp_fault = 1'b0;
        exp_ppn = '0;
        exp_size = '0;
        while (1) begin
            a = {tbl, vpn[9*(lvl-1) +: 9], 3'b000};
            exp_q.push_back(a);
            e = rd(a);
            if (!e[0]) begin exp_fault = 1'b1; break; end
            if (lvl == 1) begin exp_ppn = e[39:12]; break; end
            if (e[1]) begin
                if (lvl == 4) begin exp_fault = 1'b1; break; end
                m = (36'd1 << (9*(lvl-1))) - 36'd1;
                exp_ppn = 28'(({8'h0, e[39:12]} & ~m) | (vpn & m));
                exp_size = 2'(lvl - 1);
                break;
            end
            tbl = e[39:12];
            lvl--;
        end
    endtask

    initial begin
        bit          busy, waiting, done_due, first_rd, exp_mv;
        int          lat, wi, cyc, cur;
        logic [39:0] cur_addr;
        logic [15:0] lfsr;

        // memory image
        pmem[ea(28'h100, 1)]   = ptr_e(28'h200);
        pmem[ea(28'h200, 2)]   = ptr_e(28'h300);
        pmem[ea(28'h300, 3)]   = ptr_e(28'h400);
        pmem[ea(28'h400, 4)]   = leaf_e(28'h0ABCDE, 24'h0);
        pmem[ea(28'h400, 5)]   = ptr_e(28'h12345);
        pmem[ea(28'h300, 6)]   = leaf_e(28'h55550FF, 24'h0);
        pmem[ea(28'h200, 7)]   = leaf_e(28'h9ABCDEF, 24'hA5A5A5);
        pmem[ea(28'h100, 3)]   = leaf_e(28'h0000777, 24'h0);

        w_vpn[0] = mk_vpn(1, 2, 3, 4);         w_short[0] = 0; w_root[0] = 28'h100; w_tag[0] = "R8";
        w_vpn[1] = mk_vpn(1, 2, 3, 5);         w_short[1] = 0; w_root[1] = 28'h100; w_tag[1] = "R8";
        w_vpn[2] = mk_vpn(1, 2, 6, 9'h1A5);    w_short[2] = 0; w_root[2] = 28'h100; w_tag[2] = "R9";
        w_vpn[3] = mk_vpn(1, 7, 9'h123, 9'h0AB); w_short[3] = 0; w_root[3] = 28'h100; w_tag[3] = "R9";
        w_vpn[4] = mk_vpn(1, 2, 3, 8);         w_short[4] = 0; w_root[4] = 28'h100; w_tag[4] = "R6";
        w_vpn[5] = mk_vpn(1, 9, 0, 0);         w_short[5] = 0; w_root[5] = 28'h100; w_tag[5] = "R6";
        w_vpn[6] = mk_vpn(3, 1, 1, 1);         w_short[6] = 0; w_root[6] = 28'h100; w_tag[6] = "R7";
        w_vpn[7] = mk_vpn(9'h1FF, 2, 3, 4);    w_short[7] = 1; w_root[7] = 28'h200; w_tag[7] = "R11";
        w_vpn[8] = mk_vpn(1, 2, 3, 4);         w_short[8] = 0; w_root[8] = 28'hFFF; w_tag[8] = "R6";
        w_vpn[9] = mk_vpn(1, 2, 3, 4);         w_short[9] = 0; w_root[9] = 28'h100; w_tag[9] = "R8";

        rst = 1'b1;
        req_valid = 0; req_vpn = '0; req_short = 0; root_ppn = '0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
        chk(done_valid == 1'b0, "R1", "done_valid after reset", 64'(done_valid), 64'd0);

        busy = 0; waiting = 0; done_due = 0; first_rd = 0;
        lat = 0; wi = 0; cyc = 0; cur = 0; cur_addr = '0;
        lfsr = 16'hACE1;

        while (1) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                chk(1'b0, "R10", "watchdog expired", 64'(cyc), 64'd0);
                break;
            end
            // result pulse (R10) and its contents
            if (done_due) begin
                chk(done_valid == 1'b1, "R10", "done_valid pulse", 64'(done_valid), 64'd1);
                chk(done_fault == exp_fault, w_tag[cur], "done_fault", 64'(done_fault), 64'(exp_fault));
                chk(done_ppn == exp_ppn, w_tag[cur], "done_ppn", 64'(done_ppn), 64'(exp_ppn));
                chk(done_size == exp_size, w_tag[cur], "done_size", 64'(done_size), 64'(exp_size));
                busy = 0;
                done_due = 0;
            end else begin
                chk(done_valid == 1'b0, "R10", "done_valid idle", 64'(done_valid), 64'd0);
            end
            chk(req_ready == !busy, "R2", "req_ready", 64'(req_ready), 64'(!busy));
            exp_mv = busy && !waiting && (exp_q.size() > 0);
            chk(mem_req_valid == exp_mv, "R4", "mem_req_valid", 64'(mem_req_valid), 64'(exp_mv));

            // response to an outstanding read
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = {lfsr, lfsr, lfsr, lfsr};
            if (waiting) begin
                lat--;
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(cur_addr);
                    waiting = 0;
                    if (exp_q.size() == 0) done_due = 1;
                end
            end

            // read request handshake, with random back-pressure (R5)
            mem_req_ready = lfsr[0] | lfsr[1];
            if (exp_mv) begin
                chk(mem_req_addr == exp_q[0], first_rd ? "R3" : "R4", "mem_req_addr",
                    64'(mem_req_addr), 64'(exp_q[0]));
                if (mem_req_ready) begin
                    cur_addr = exp_q.pop_front();
                    waiting = 1;
                    first_rd = 0;
                    lat = 1 + int'(lfsr[3:2]);
                end
            end

            // new walk when idle, junk requests while busy (R2)
            if (!busy && wi < NW) begin
                req_valid = 1'b1;
                req_vpn   = w_vpn[wi];
                req_short = w_short[wi];
                root_ppn  = w_root[wi];
                ref_walk(w_vpn[wi], w_short[wi], w_root[wi]);
                cur = wi;
                wi++;
                busy = 1;
                first_rd = 1;
            end else if (busy) begin
                req_valid = lfsr[4];
                req_vpn   = {lfsr[3:0], lfsr, lfsr};
                req_short = lfsr[5];
                root_ppn  = {lfsr[11:0], lfsr};
            end else begin
                req_valid = 1'b0;
                if (wi >= NW && !done_due) break;
            end

            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule